// File: doc/BRIEF.md
# Lock Ownership Directory

This block is a hardware directory for mutex ownership in a multiprocessor system that lacks cache coherency. Each command names a lock and a process. A *request* always makes the requester the recorded owner of that lock. The reply depends on the previous state of the lock. If the lock had no entry, the reply is "granted". If the lock already had an owner, the reply names that previous owner, and the requester must then go and ask that process for the lock. Each request therefore appends the requester to a first-come-first-served chain spread across the processors. A *give-up* removes a lock's entry, but only when the process giving it up is still the recorded owner.

The directory is a small fully associative table. Each entry holds a lock ID, an owner ID and a valid bit. A lock with no entry counts as free. Commands arrive on a valid/ready input and are taken one per cycle in arrival order. Every accepted command produces exactly one response, two cycles after it is accepted. Each command sees the table changes made by every command accepted before it.

Top module: `lock_owner_dir`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` is 0. From the first cycle after reset, `cmd_ready` is 1 and the table is empty.
- R2: A request (`cmd_op`=0) for a lock with no entry records the requester as owner and replies with code 0 (granted) and `rsp_owner`=0.
- R3: A request for a lock whose recorded owner is p replies with code 1 (ask) and `rsp_owner`=p, and it makes the requester the new recorded owner.
- R4: A request from the process that is already the recorded owner still replies with code 1 and that same process in `rsp_owner`. The entry is unchanged.
- R5: A give-up (`cmd_op`=1) from the recorded owner removes the entry and replies with code 3 (acknowledge). A later request for that lock is granted.
- R6: A give-up from a process that is not the recorded owner replies with code 3 and leaves the recorded owner unchanged.
- R7: A give-up for a lock with no entry replies with code 3 and creates no entry.
- R8: A request for a lock with no entry while all ENTRIES slots are in use replies with code 2 (retry) and changes nothing. Requests for locks already held keep working. Once a slot is freed, a new lock can be granted.
- R9: Each accepted command produces exactly one response, with `rsp_valid` high in the second cycle after the accepting cycle. `rsp_valid` is never high otherwise.
- R10: Commands accepted in consecutive cycles are answered in consecutive cycles, in the same order. Each command observes the table updates of all earlier commands.
- R11: The table never holds more than one valid entry for the same lock ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Directory accepts a command this cycle |
| cmd_op | input | 1 | 0 = request, 1 = give-up |
| cmd_lock | input | LOCK_W | Lock ID |
| cmd_proc | input | PROC_W | Process ID issuing the command |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_code | output | 2 | 0 granted, 1 ask, 2 retry, 3 acknowledge |
| rsp_owner | output | PROC_W | Previous owner on an ask response, else 0 |

## Verification
The bench builds ownership chains in which the third requester is told to ask the second requester, not the first. A design that failed to replace the owner on a hit would name the wrong process. It also checks that a stranger's give-up leaves the chain intact, and that a give-up for an unknown lock does not allocate an entry. Either fault would turn a later ask into a grant, or a grant into an ask. The table is filled to capacity to provoke a retry and to confirm that nothing was installed by it. Commands are issued back to back to expose a pipeline that answers from a stale table.

// File: rtl/lod_pkg.sv
// Shared encodings for the lock ownership directory.
package lod_pkg;

    typedef enum logic {
        OP_REQUEST = 1'b0,
        OP_GIVEUP  = 1'b1
    } lod_op_e;

    typedef enum logic [1:0] {
        RSP_GRANT = 2'd0,
        RSP_ASK   = 2'd1,
        RSP_RETRY = 2'd2,
        RSP_ACK   = 2'd3
    } lod_rsp_e;

endpackage

// File: rtl/lod_table.sv
// Entry storage of the directory: ENTRIES registers of {valid, lock, owner}.
// Assumes at most one write per cycle; a write sets all fields of one slot.
module lod_table #(
    parameter int ENTRIES = 16,
    parameter int LOCK_W  = 8,
    parameter int PROC_W  = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [LOCK_W-1:0]  wr_lock,
    input  logic [PROC_W-1:0]  wr_owner,
    output logic [ENTRIES-1:0] valid_q,
    output logic [LOCK_W-1:0]  lock_q  [ENTRIES],
    output logic [PROC_W-1:0]  owner_q [ENTRIES]
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        // Update one slot when the write index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                lock_q[e]  <= '0;
                owner_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                valid_q[e] <= wr_valid;
                lock_q[e]  <= wr_lock;
                owner_q[e] <= wr_owner;
            end
        end
    end

endmodule

// File: rtl/lod_match.sv
// Associative search: finds the slot holding a lock ID and the lowest free slot.
// Assumes the table keeps lock IDs unique among valid slots (checked here).
module lod_match #(
    parameter int ENTRIES = 16,
    parameter int LOCK_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_q,
    input  logic [LOCK_W-1:0]  lock_q [ENTRIES],
    input  logic [LOCK_W-1:0]  key,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               full,
    output logic [IDX_W-1:0]   free_idx
);

    logic [ENTRIES-1:0] hit_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = valid_q[e] && (lock_q[e] == key);
    end

    // Encode the matching slot; at most one bit is set.
    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e]) hit_idx = IDX_W'(e);
        end
    end

    // Pick the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!valid_q[e]) free_idx = IDX_W'(e);
        end
    end

    assign hit  = |hit_vec;
    assign full = &valid_q;

    AST_UNIQUE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R11

endmodule

// File: rtl/lod_decide.sv
// Command decision: turns a lookup result into a table write and a response.
// Assumes a single command per cycle; purely combinational.
module lod_decide
    import lod_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PROC_W  = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              cmd_en,
    input  lod_op_e           op,
    input  logic [PROC_W-1:0] proc,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [PROC_W-1:0] hit_owner,
    input  logic              full,
    input  logic [IDX_W-1:0]  free_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_valid,
    output lod_rsp_e          rsp_code,
    output logic [PROC_W-1:0] rsp_owner
);

    // Decide the table update and the reply for the staged command.
    always_comb begin
        wr_en     = 1'b0;
        wr_idx    = hit_idx;
        wr_valid  = 1'b1;
        rsp_code  = RSP_ACK;
        rsp_owner = '0;
        if (op == OP_REQUEST) begin
            if (hit) begin
                wr_en     = cmd_en;
                rsp_code  = RSP_ASK;
                rsp_owner = hit_owner;
            end else if (!full) begin
                wr_en    = cmd_en;
                wr_idx   = free_idx;
                rsp_code = RSP_GRANT;
            end else begin
                rsp_code = RSP_RETRY;
            end
        end else begin
            if (hit && (hit_owner == proc)) begin
                wr_en    = cmd_en;
                wr_valid = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lock_owner_dir.sv
// Lock ownership directory top. Stage 1 registers the accepted command;
// stage 2 searches the table, updates it and registers the response.
// Assumes the response consumer is always able to take a response.
module lock_owner_dir
    import lod_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int LOCK_W  = 8,
    parameter int PROC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [LOCK_W-1:0] cmd_lock,
    input  logic [PROC_W-1:0] cmd_proc,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [PROC_W-1:0] rsp_owner
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic               accept;
    logic               s1_valid;
    lod_op_e            s1_op;
    logic [LOCK_W-1:0]  s1_lock;
    logic [PROC_W-1:0]  s1_proc;

    logic [ENTRIES-1:0] valid_q;
    logic [LOCK_W-1:0]  lock_q  [ENTRIES];
    logic [PROC_W-1:0]  owner_q [ENTRIES];

    logic               hit;
    logic               full;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic               wr_valid;
    lod_rsp_e           dec_code;
    logic [PROC_W-1:0]  dec_owner;

    assign accept = cmd_valid && cmd_ready;

    // Ready rises once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_ready <= 1'b0;
        else        cmd_ready <= 1'b1;
    end

    // Stage 1: capture the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_REQUEST;
            s1_lock  <= '0;
            s1_proc  <= '0;
        end else begin
            s1_valid <= accept;
            s1_op    <= lod_op_e'(cmd_op);
            s1_lock  <= cmd_lock;
            s1_proc  <= cmd_proc;
        end
    end

    lod_table #(.ENTRIES(ENTRIES), .LOCK_W(LOCK_W), .PROC_W(PROC_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_lock  (s1_lock),
        .wr_owner (s1_proc),
        .valid_q  (valid_q),
        .lock_q   (lock_q),
        .owner_q  (owner_q)
    );

    lod_match #(.ENTRIES(ENTRIES), .LOCK_W(LOCK_W)) i_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_q  (valid_q),
        .lock_q   (lock_q),
        .key      (s1_lock),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .full     (full),
        .free_idx (free_idx)
    );

    lod_decide #(.ENTRIES(ENTRIES), .PROC_W(PROC_W)) i_decide (
        .cmd_en    (s1_valid),
        .op        (s1_op),
        .proc      (s1_proc),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_owner (owner_q[hit_idx]),
        .full      (full),
        .free_idx  (free_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .rsp_code  (dec_code),
        .rsp_owner (dec_owner)
    );

    // Stage 2: register the response of the staged command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_owner <= '0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_code  <= s1_valid ? dec_code  : '0;
            rsp_owner <= s1_valid ? dec_owner : '0;
        end
    end

    AST_RSP_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 rsp_valid); // R9
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(accept, 2)); // R9
    AST_RETRY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_op == OP_REQUEST && !hit && full) |=> $stable(valid_q)); // R8
    AST_GIVEUP_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_op == OP_GIVEUP) |=>
            ($countones(valid_q) <= $past($countones(valid_q)))); // R7

endmodule

// File: tb/test_lock_owner_dir.sv
module test_lock_owner_dir;

    localparam int LOCK_W = 8;
    localparam int PROC_W = 5;
    localparam int NENT   = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic              cmd_ready;
    logic              cmd_op;
    logic [LOCK_W-1:0] cmd_lock;
    logic [PROC_W-1:0] cmd_proc;
    logic              rsp_valid;
    logic [1:0]        rsp_code;
    logic [PROC_W-1:0] rsp_owner;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    lock_owner_dir #(.ENTRIES(NENT), .LOCK_W(LOCK_W), .PROC_W(PROC_W)) i_lock_owner_dir (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_lock(cmd_lock), .cmd_proc(cmd_proc),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_owner(rsp_owner)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_lock = '0; cmd_proc = '0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(cmd_ready), 1);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    endtask

    // One command; checks latency and the response fields.
    task automatic cmd(string req, bit op, int lock, int proc, int exp_code, int exp_owner);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_lock = LOCK_W'(lock); cmd_proc = PROC_W'(proc);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " R9 no early rsp"}, int'(rsp_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check({req, " R9 rsp_valid"}, int'(rsp_valid), 1);
        check({req, " code"}, int'(rsp_code), exp_code);
        check({req, " owner"}, int'(rsp_owner), exp_owner);
    endtask

    task automatic t_chain();
        do_reset();
        cmd("R2 first request", 0, 8'h21, 1, 0, 0);
        cmd("R3 second request", 0, 8'h21, 2, 1, 1);
        cmd("R3 third request asks second", 0, 8'h21, 3, 1, 2);
        cmd("R4 owner re-request", 0, 8'h21, 3, 1, 3);
    endtask

    task automatic t_giveup();
        do_reset();
        cmd("R2 grant", 0, 8'h30, 4, 0, 0);
        cmd("R6 stranger give-up", 1, 8'h30, 5, 3, 0);
        cmd("R6 owner kept", 0, 8'h30, 6, 1, 4);
        cmd("R5 owner give-up", 1, 8'h30, 6, 3, 0);
        cmd("R5 freed then granted", 0, 8'h30, 7, 0, 0);
        cmd("R7 absent give-up", 1, 8'h10, 1, 3, 0);
        cmd("R7 no entry created", 0, 8'h10, 2, 0, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < NENT; k++) cmd("R8 fill", 0, 8'h40 + k, 1, 0, 0);
        cmd("R8 full retry", 0, 8'h60, 2, 2, 0);
        cmd("R8 retry again", 0, 8'h60, 2, 2, 0);
        cmd("R8 held lock still works", 0, 8'h45, 3, 1, 1);
        cmd("R8 free one", 1, 8'h45, 3, 3, 0);
        cmd("R8 grant after free", 0, 8'h60, 2, 0, 0);
        cmd("R8 retry installed nothing", 0, 8'h60, 4, 1, 2);
    endtask

    // Three commands in consecutive cycles; responses in consecutive cycles.
    task automatic t_burst();
        do_reset();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_lock = 8'h77; cmd_proc = 5'd9;
        @(posedge clk); @(negedge clk);
        cmd_proc = 5'd10;
        @(posedge clk); @(negedge clk);
        check("R10 rsp1 valid", int'(rsp_valid), 1);
        check("R10 rsp1 code", int'(rsp_code), 0);
        cmd_op = 1'b1; cmd_proc = 5'd10;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 rsp2 valid", int'(rsp_valid), 1);
        check("R10 rsp2 code", int'(rsp_code), 1);
        check("R10 rsp2 owner", int'(rsp_owner), 9);
        @(posedge clk); @(negedge clk);
        check("R10 rsp3 valid", int'(rsp_valid), 1);
        check("R10 rsp3 code", int'(rsp_code), 3);
        @(posedge clk); @(negedge clk);
        check("R9 single rsp per cmd", int'(rsp_valid), 0);
        cmd("R10 give-up took effect", 0, 8'h77, 11, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_lock = '0; cmd_proc = '0;
        t_chain();
        t_giveup();
        t_full();
        t_burst();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule